// File: doc/BRIEF.md
# Asynchronous CPU bus to Wishbone bridge

This block lets a CPU or microcontroller with a plain strobe-driven external bus reach Wishbone peripherals. On the CPU side it behaves as a memory-mapped slave. The CPU drives an address, an active-low chip select, active-low read or write strobes and active-low byte enables, and it shares a bidirectional data bus with the bridge. The bridge turns each strobe into one Wishbone master transfer. It stretches the CPU access through an active-low wait output until the Wishbone slave has answered.

The CPU strobes have no relation to the bridge clock, so they pass through a synchroniser before they are used. Address, byte enables and write data are captured when the synchronised strobe starts a transfer. By then the CPU has held them stable for at least two clocks. CYC stays asserted for as long as chip select stays low. A read followed by a write to the same location therefore forms one locked read-modify-write cycle, and several strobes under one chip select form a block cycle. A retry response makes the bridge issue the same transfer again. An error response ends the CPU access with all-ones read data.

Top module: `async_bus_wb_bridge`

## Requirements
- R1: After reset, with chip select high, wb_cyc_o and wb_stb_o are low and cpu_wait_n_o is high.
- R2: A CPU read issues one Wishbone transfer with wb_we_o=0, wb_adr_o equal to cpu_addr_i[ADDR_W-1:1], and wb_sel_o[i] equal to the inverse of cpu_be_n_i[i].
- R3: cpu_wait_n_o is low while chip select is low together with a read or write strobe and the current transfer has not completed. It goes high in the clock after the edge on which ACK or ERR is sampled.
- R4: The wb_dat_i value sampled with ACK on a read is driven onto cpu_data_io while chip select and read are both low. It stays there until the read strobe rises.
- R5: A CPU write issues one transfer with wb_we_o=1, wb_dat_o equal to the CPU data, and address and select mapped as in R2.
- R6: On RTY, wb_stb_o drops for exactly one clock while wb_cyc_o stays high and wait stays low. STB then returns with unchanged address, select, write enable and data.
- R7: On ERR the wait output is released. A read that ends in ERR returns all ones on cpu_data_io.
- R8: While chip select stays low, wb_cyc_o stays high between consecutive strobes and wb_stb_o stays low between them. wb_cyc_o drops once chip select has risen.
- R9: wb_stb_o is never high while wb_cyc_o is low.
- R10: A read or write strobe with chip select high starts no transfer and does not assert wait.
- R11: Each CPU strobe produces a single accepted transfer. After ACK or ERR, STB stays low until the strobe is released and asserted again.
- R12: wb_stb_o goes high on the third rising clock edge after the strobe falls: two synchroniser stages and one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge and Wishbone clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | ADDR_W | CPU byte address |
| cpu_data_io | inout | DATA_W | Shared CPU data bus |
| cpu_cs_n_i | input | 1 | Chip select, active low |
| cpu_rd_n_i | input | 1 | Read strobe, active low |
| cpu_wr_n_i | input | 1 | Write strobe, active low |
| cpu_be_n_i | input | DATA_W/8 | Byte enables, active low |
| cpu_wait_n_o | output | 1 | Wait to the CPU, active low |
| wb_cyc_o | output | 1 | Wishbone cycle frame |
| wb_stb_o | output | 1 | Wishbone transfer strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | DATA_W/8 | Wishbone byte selects |
| wb_adr_o | output | ADDR_W-1 | Wishbone word address |
| wb_dat_o | output | DATA_W | Write data to the slave |
| wb_dat_i | input | DATA_W | Read data from the slave |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_rty_i | input | 1 | Slave retry request |
| wb_err_i | input | 1 | Slave error |

## Verification
If the sequencer state is wrong, STB fails to drop in the clock after ACK or RTY. Wait also fails to release one clock after a completion, so the fault shows at the ports within one cycle of a response. Faults in the capture registers show on wb_adr_o, wb_sel_o or wb_dat_o as soon as STB rises, which is three clocks after the strobe. A read-data register that is never loaded, or loaded at the wrong moment, shows on the CPU bus in the first sample after wait is released. A lost CYC lock shows within four clocks of a strobe release while chip select is still low.

// File: rtl/abw_pkg.sv
package abw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_XFER  = 3'd1,
      ST_RETRY = 3'd2,
      ST_DONE  = 3'd3,
      ST_HOLD  = 3'd4
   } abw_state_e;

   localparam int unsigned ABW_MIN_SYNC = 2;
endpackage

// File: rtl/abw_sync.sv
module abw_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain_q [STAGES];

   genvar gs;
   generate
      for (gs = 0; gs < STAGES; gs++) begin : g_stage
         if (gs == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[gs] <= INIT;
               else       chain_q[gs] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[gs] <= INIT;
               else       chain_q[gs] <= chain_q[gs-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/abw_seq.sv
module abw_seq
   import abw_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic cs_a_i,
   input  logic rd_a_i,
   input  logic wr_a_i,
   input  logic ack_i,
   input  logic rty_i,
   input  logic err_i,
   output logic cyc_o,
   output logic stb_o,
   output logic capture_o,
   output logic in_done_o,
   output logic cmp_ack_o,
   output logic cmp_err_o
);
   abw_state_e state_q, state_d;
   logic       req_a;

   assign req_a = cs_a_i & (rd_a_i | wr_a_i);

   always_comb begin
      state_d   = state_q;
      capture_o = 1'b0;
      cmp_ack_o = 1'b0;
      cmp_err_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_a) begin
               capture_o = 1'b1;
               state_d   = ST_XFER;
            end
         end
         ST_XFER: begin
            if (ack_i) begin
               cmp_ack_o = 1'b1;
               state_d   = ST_DONE;
            end else if (err_i) begin
               cmp_err_o = 1'b1;
               state_d   = ST_DONE;
            end else if (rty_i) begin
               state_d   = ST_RETRY;
            end
         end
         ST_RETRY: state_d = ST_XFER;
         ST_DONE: begin
            if (!(rd_a_i | wr_a_i)) state_d = cs_a_i ? ST_HOLD : ST_IDLE;
         end
         ST_HOLD: begin
            if (!cs_a_i) begin
               state_d = ST_IDLE;
            end else if (req_a) begin
               capture_o = 1'b1;
               state_d   = ST_XFER;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= ST_IDLE;
      else       state_q <= state_d;
   end

   assign cyc_o     = (state_q != ST_IDLE);
   assign stb_o     = (state_q == ST_XFER);
   assign in_done_o = (state_q == ST_DONE);
endmodule

// File: rtl/abw_datapath.sv
module abw_datapath #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned SEL_W = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              capture_i,
   input  logic              wr_a_i,
   input  logic              cmp_ack_i,
   input  logic              cmp_err_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [SEL_W-1:0]  cpu_be_n_i,
   input  logic [DATA_W-1:0] cpu_data_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [ADDR_W-2:0] wb_adr_o,
   output logic [SEL_W-1:0]  wb_sel_o,
   output logic              wb_we_o,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [ADDR_W-2:0] adr_q;
   logic [SEL_W-1:0]  sel_q;
   logic              we_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] rdat_q;
   logic              unused_byte_bit;

   assign unused_byte_bit = cpu_addr_i[0];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         adr_q  <= '0;
         we_q   <= 1'b0;
         wdat_q <= '0;
      end else if (capture_i) begin
         adr_q  <= cpu_addr_i[ADDR_W-1:1];
         we_q   <= wr_a_i;
         wdat_q <= cpu_data_i;
      end
   end

   genvar gb;
   generate
      for (gb = 0; gb < SEL_W; gb++) begin : g_sel
         always_ff @(posedge clk_i) begin
            if (rst_i)          sel_q[gb] <= 1'b0;
            else if (capture_i) sel_q[gb] <= ~cpu_be_n_i[gb];
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rdat_q <= '0;
      end else if (!we_q) begin
         if (cmp_ack_i)      rdat_q <= wb_dat_i;
         else if (cmp_err_i) rdat_q <= '1;
      end
   end

   assign wb_adr_o = adr_q;
   assign wb_sel_o = sel_q;
   assign wb_we_o  = we_q;
   assign wb_dat_o = wdat_q;
   assign rdata_o  = rdat_q;
endmodule

// File: rtl/async_bus_wb_bridge.sv
module async_bus_wb_bridge
   import abw_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   inout  wire  [DATA_W-1:0] cpu_data_io,
   input  logic              cpu_cs_n_i,
   input  logic              cpu_rd_n_i,
   input  logic              cpu_wr_n_i,
   input  logic [SEL_W-1:0]  cpu_be_n_i,
   output logic              cpu_wait_n_o,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   output logic              wb_we_o,
   output logic [SEL_W-1:0]  wb_sel_o,
   output logic [ADDR_W-2:0] wb_adr_o,
   output logic [DATA_W-1:0] wb_dat_o,
   input  logic [DATA_W-1:0] wb_dat_i,
   input  logic              wb_ack_i,
   input  logic              wb_rty_i,
   input  logic              wb_err_i
);
   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < ABW_MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]        strb_sync;
   logic              cs_a, rd_a, wr_a;
   logic              capture, in_done, cmp_ack, cmp_err;
   logic [DATA_W-1:0] rdata;
   logic              raw_req, drive_en;

   abw_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .INIT   (3'b111)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i ({cpu_cs_n_i, cpu_rd_n_i, cpu_wr_n_i}),
      .sync_o  (strb_sync)
   );

   assign cs_a = ~strb_sync[2];
   assign rd_a = ~strb_sync[1];
   assign wr_a = ~strb_sync[0];

   abw_seq u_seq (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cs_a_i    (cs_a),
      .rd_a_i    (rd_a),
      .wr_a_i    (wr_a),
      .ack_i     (wb_ack_i),
      .rty_i     (wb_rty_i),
      .err_i     (wb_err_i),
      .cyc_o     (wb_cyc_o),
      .stb_o     (wb_stb_o),
      .capture_o (capture),
      .in_done_o (in_done),
      .cmp_ack_o (cmp_ack),
      .cmp_err_o (cmp_err)
   );

   abw_datapath #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_dp (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .capture_i  (capture),
      .wr_a_i     (wr_a),
      .cmp_ack_i  (cmp_ack),
      .cmp_err_i  (cmp_err),
      .cpu_addr_i (cpu_addr_i),
      .cpu_be_n_i (cpu_be_n_i),
      .cpu_data_i (cpu_data_io),
      .wb_dat_i   (wb_dat_i),
      .wb_adr_o   (wb_adr_o),
      .wb_sel_o   (wb_sel_o),
      .wb_we_o    (wb_we_o),
      .wb_dat_o   (wb_dat_o),
      .rdata_o    (rdata)
   );

   assign raw_req      = ~cpu_cs_n_i & (~cpu_rd_n_i | ~cpu_wr_n_i);
   assign cpu_wait_n_o = ~(raw_req & ~in_done);
   assign drive_en     = ~cpu_cs_n_i & ~cpu_rd_n_i;
   assign cpu_data_io  = drive_en ? rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/abw_checker.sv
module abw_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned SEL_W = DATA_W / 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              cpu_cs_n_i,
   input logic              cpu_rd_n_i,
   input logic              cpu_wr_n_i,
   input logic              cpu_wait_n_o,
   input logic              wb_cyc_o,
   input logic              wb_stb_o,
   input logic              wb_we_o,
   input logic [SEL_W-1:0]  wb_sel_o,
   input logic [ADDR_W-2:0] wb_adr_o,
   input logic [DATA_W-1:0] wb_dat_o,
   input logic              wb_ack_i,
   input logic              wb_rty_i,
   input logic              wb_err_i
);
   logic retry_only;
   assign retry_only = wb_stb_o & wb_rty_i & ~wb_ack_i & ~wb_err_i;

   assert_stb_in_cyc_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      wb_stb_o |-> wb_cyc_o);

   assert_single_xfer_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (wb_stb_o && wb_ack_i) |=> !wb_stb_o);

   assert_retry_gap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      retry_only |=> (wb_cyc_o && !wb_stb_o));

   assert_retry_same_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      retry_only |=> ($stable(wb_adr_o) && $stable(wb_sel_o) &&
                      $stable(wb_we_o) && $stable(wb_dat_o)));

   assert_err_release_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (wb_stb_o && wb_err_i && !wb_ack_i) |=> cpu_wait_n_o);

   assert_wait_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (wb_stb_o && !cpu_cs_n_i && !(cpu_rd_n_i && cpu_wr_n_i)) |-> !cpu_wait_n_o);

   assert_cs_start_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(wb_cyc_o) |-> $past(!cpu_cs_n_i, 2));
endmodule

bind async_bus_wb_bridge abw_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .cpu_cs_n_i   (cpu_cs_n_i),
   .cpu_rd_n_i   (cpu_rd_n_i),
   .cpu_wr_n_i   (cpu_wr_n_i),
   .cpu_wait_n_o (cpu_wait_n_o),
   .wb_cyc_o     (wb_cyc_o),
   .wb_stb_o     (wb_stb_o),
   .wb_we_o      (wb_we_o),
   .wb_sel_o     (wb_sel_o),
   .wb_adr_o     (wb_adr_o),
   .wb_dat_o     (wb_dat_o),
   .wb_ack_i     (wb_ack_i),
   .wb_rty_i     (wb_rty_i),
   .wb_err_i     (wb_err_i)
);

// File: tb/async_bus_wb_bridge_tb.sv
module async_bus_wb_bridge_tb;
   localparam int DW = 16;
   localparam int AW = 16;
   localparam int SW = DW / 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [SW-1:0] be_n = '1;
   logic          tb_drv = 1'b0;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] data;
   logic          wait_n, cyc, stb, we;
   logic [SW-1:0] sel;
   logic [AW-2:0] adr;
   logic [DW-1:0] dato;
   logic [DW-1:0] dati = '0;
   logic          ack = 1'b0, rty = 1'b0, err = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   assign data = tb_drv ? tb_val : {DW{1'bz}};

   always #2 clk = ~clk;

   async_bus_wb_bridge #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk_i(clk), .rst_i(rst), .cpu_addr_i(addr), .cpu_data_io(data),
      .cpu_cs_n_i(cs_n), .cpu_rd_n_i(rd_n), .cpu_wr_n_i(wr_n), .cpu_be_n_i(be_n),
      .cpu_wait_n_o(wait_n), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we),
      .wb_sel_o(sel), .wb_adr_o(adr), .wb_dat_o(dato), .wb_dat_i(dati),
      .wb_ack_i(ack), .wb_rty_i(rty), .wb_err_i(err)
   );

   function automatic logic [AW-2:0] exp_adr(input logic [AW-1:0] a);
      return a[AW-1:1];
   endfunction

   function automatic logic [SW-1:0] exp_sel(input logic [SW-1:0] b);
      return ~b;
   endfunction

   function automatic logic [DW-1:0] exp_rdata(input int kind, input logic [DW-1:0] d);
      return (kind == 2) ? {DW{1'b1}} : d;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic start_acc(input bit is_wr, input logic [AW-1:0] a,
                            input logic [SW-1:0] b, input logic [DW-1:0] wd);
      @(negedge clk);
      addr = a; be_n = b; cs_n = 1'b0;
      if (is_wr) begin tb_drv = 1'b1; tb_val = wd; wr_n = 1'b0; end
      else       begin tb_drv = 1'b0; rd_n = 1'b0; end
      #1 chk(wait_n == 1'b0, "R3", "wait asserted at strobe", 32'(wait_n), 0);
   endtask

   task automatic slave(input int kind, input bit is_wr, input logic [AW-1:0] a,
                        input logic [SW-1:0] b, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rd);
      int n = 0;
      do begin @(negedge clk); n++; end while (!stb && n < 20);
      chk(n == 3, "R12", "strobe-to-STB latency", 32'(n), 3);
      chk(adr == exp_adr(a), is_wr ? "R5" : "R2", "address", 32'(adr), 32'(exp_adr(a)));
      chk(sel == exp_sel(b), is_wr ? "R5" : "R2", "select", 32'(sel), 32'(exp_sel(b)));
      chk(we == is_wr, is_wr ? "R5" : "R2", "write enable", 32'(we), 32'(is_wr));
      if (is_wr) chk(dato == wd, "R5", "write data", 32'(dato), 32'(wd));
      if (kind == 1) begin
         rty = 1'b1;
         @(negedge clk); rty = 1'b0;
         chk(!stb && cyc, "R6", "STB gap with CYC held", {cyc, stb}, 32'b10);
         chk(wait_n == 1'b0, "R6", "wait kept during retry", 32'(wait_n), 0);
         @(negedge clk);
         chk(stb == 1'b1, "R6", "STB re-issued", 32'(stb), 1);
         chk(adr == exp_adr(a) && sel == exp_sel(b) && we == is_wr,
             "R6", "retry same transfer", 32'(adr), 32'(exp_adr(a)));
      end
      if (kind == 2) err = 1'b1;
      else begin ack = 1'b1; dati = rd; end
      @(negedge clk); ack = 1'b0; err = 1'b0; dati = $urandom;
      chk(stb == 1'b0, "R11", "STB low after completion", 32'(stb), 0);
      chk(wait_n == 1'b1, kind == 2 ? "R7" : "R3", "wait released", 32'(wait_n), 1);
      if (!is_wr)
         chk(data == exp_rdata(kind, rd), kind == 2 ? "R7" : "R4", "read data",
             32'(data), 32'(exp_rdata(kind, rd)));
   endtask

   task automatic end_acc(input bit is_wr, input bit keep_cs, input logic [DW-1:0] exp_rd);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(stb == 1'b0, "R11", "no second transfer", 32'(stb), 0);
         if (!is_wr) chk(data == exp_rd, "R4", "read data held", 32'(data), 32'(exp_rd));
      end
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; tb_drv = 1'b0;
      if (!keep_cs) cs_n = 1'b1;
      repeat (4) @(negedge clk);
      if (keep_cs) chk(cyc && !stb, "R8", "CYC locked between strobes", {cyc, stb}, 32'b10);
      else         chk(!cyc, "R8", "CYC dropped after chip select", 32'(cyc), 0);
   endtask

   task automatic access(input bit is_wr, input int kind, input bit keep_cs,
                         input logic [AW-1:0] a, input logic [SW-1:0] b,
                         input logic [DW-1:0] wd, input logic [DW-1:0] rd);
      start_acc(is_wr, a, b, wd);
      slave(kind, is_wr, a, b, wd, rd);
      end_acc(is_wr, keep_cs, exp_rdata(kind, rd));
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!cyc && !stb && wait_n, "R1", "reset state", {cyc, stb, wait_n}, 32'b001);

      // R10: read strobe with chip select high
      rd_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(!cyc && !stb && wait_n, "R10", "no access without chip select",
             {cyc, stb, wait_n}, 32'b001);
      end
      rd_n = 1'b1;
      repeat (3) @(negedge clk);

      access(1'b0, 0, 1'b0, 16'h1235, 2'b00, '0, 16'hA5C3);
      access(1'b1, 0, 1'b0, 16'h00F0, 2'b10, 16'h5A11, '0);
      access(1'b0, 1, 1'b0, 16'hFFFE, 2'b01, '0, 16'h0F0F);
      access(1'b1, 1, 1'b0, 16'h8000, 2'b00, 16'hBEEF, '0);
      access(1'b0, 2, 1'b0, 16'h0002, 2'b00, '0, 16'h1234);
      access(1'b1, 2, 1'b0, 16'h4444, 2'b11, 16'hCAFE, '0);

      // R8: read-modify-write under one chip select
      access(1'b0, 0, 1'b1, 16'h0A0A, 2'b00, '0, 16'h00FF);
      access(1'b1, 0, 1'b0, 16'h0A0A, 2'b00, 16'h01FF, '0);

      for (int it = 0; it < 60; it++) begin
         bit            w  = 1'($urandom);
         int            k  = int'($urandom % 3);
         bit            kc = (it != 59) && (($urandom % 4) == 0);
         logic [AW-1:0] a  = AW'($urandom);
         logic [SW-1:0] b  = SW'($urandom);
         logic [DW-1:0] wd = DW'($urandom);
         logic [DW-1:0] rd = DW'($urandom);
         access(w, k, kc, a, b, wd, rd);
      end
      summary();
   end
endmodule